// File: doc/BRIEF.md
# Reverse-channel run-length expander

This block sits behind the receive side of a bidirectional parallel-port link running in its extended-capability mode. Bytes arriving from the peripheral carry a tag: a data byte goes toward a receive FIFO, and a command byte carries a run-length count. A valid count makes the next data byte expand into several identical bytes in the FIFO. The count byte itself never reaches the FIFO.

The upstream side offers one byte per handshake (`in_valid`/`in_ready`). The downstream side is the write port of a FIFO that can push back with `fifo_full`. While a byte is being replicated, the block refuses new input. A command with its top bit set can never legally appear on this channel. Such a command is dropped and raises a sticky error flag.

Top module: `ecp_rle_expander`

## Requirements
- R1: After reset `fifo_wr` is 0, `in_ready` is 1 and `err_cmd` is 0.
- R2: A byte accepted with `in_tag_data`=1 and no pending count is written to the FIFO exactly once. A byte accepted with `in_tag_data`=0 is never written to the FIFO.
- R3: A command byte whose bit 7 is 0 sets a pending count N from bits 6:0. The next accepted data byte is then written N+1 times in a row with its value unchanged, so N=0 gives 1 copy and N=127 gives 128 copies.
- R4: Once a data byte has consumed a count, the pending count is back to zero, so the following data byte is written once.
- R5: A second count command that arrives before any data byte replaces the first one.
- R6: A command byte with bit 7 = 1 sets `err_cmd`. It is discarded, produces no FIFO write and leaves the pending count unchanged.
- R7: From the cycle after a data byte is accepted until its last copy is written, `in_ready` is 0.
- R8: `fifo_wr` is never 1 while `fifo_full` is 1. A stall delays the copies but does not lose any of them.
- R9: Once `err_cmd` is set, it stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Received byte offered |
| in_tag_data | input | 1 | 1 = data byte, 0 = command byte |
| in_byte | input | 8 | Received byte |
| in_ready | output | 1 | Byte accepted on a clock edge when in_valid is also 1 |
| fifo_full | input | 1 | Receive FIFO cannot take a write |
| fifo_wr | output | 1 | Write strobe to the receive FIFO |
| fifo_data | output | 8 | Byte written to the receive FIFO |
| err_cmd | output | 1 | Sticky: illegal command (bit 7 set) received |

## Verification
Directed sequences feed the block the following input patterns:
- A bare data byte. This separates pass-through from replication.
- Counts of 0, 3 and 127. These expose off-by-one errors at both ends of the count range.
- A count followed by two data bytes. This shows whether the count is cleared after use.
- Two counts back to back. This shows whether the second count replaces the first or is added to it.
- An illegal command placed between a count and its data byte. This shows that the command is dropped without disturbing the pending count.
- A held and then toggling `fifo_full`. This shows that copies are only delayed and never dropped or duplicated.

// File: rtl/ecp_rle_expander.sv
module ecp_rle_expander #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_tag_data,
  input  logic [BYTE_W-1:0] in_byte,
  output logic              in_ready,
  input  logic              fifo_full,
  output logic              fifo_wr,
  output logic [BYTE_W-1:0] fifo_data,
  output logic              err_cmd
);
  localparam int CNT_W = BYTE_W - 1;

  logic [CNT_W-1:0]  pend_q, left_q;
  logic [BYTE_W-1:0] hold_q;
  logic              busy_q, err_q;
  logic              take;

  assign in_ready  = !busy_q;
  assign take      = in_valid && in_ready;
  assign fifo_wr   = busy_q && !fifo_full;
  assign fifo_data = hold_q;
  assign err_cmd   = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      left_q <= '0;
      hold_q <= '0;
      busy_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (take) begin
        if (in_tag_data) begin
          hold_q <= in_byte;
          left_q <= pend_q;
          pend_q <= '0;
          busy_q <= 1'b1;
        end else if (in_byte[BYTE_W-1]) begin
          err_q <= 1'b1;
        end else begin
          pend_q <= in_byte[CNT_W-1:0];
        end
      end
      if (fifo_wr) begin
        if (left_q == '0) busy_q <= 1'b0;
        else              left_q <= left_q - 1'b1;
      end
    end
  end
endmodule

module ecp_rle_expander_chk #(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_tag_data,
  input logic [BYTE_W-1:0] in_byte,
  input logic              in_ready,
  input logic              fifo_full,
  input logic              fifo_wr,
  input logic [BYTE_W-1:0] fifo_data,
  input logic              err_cmd
);
  p_cmd_no_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !in_tag_data |=> !fifo_wr);
  p_ready_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr |-> !in_ready);
  p_hold_byte_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> (in_ready || $stable(fifo_data)));
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full |-> !fifo_wr);
  p_bad_cmd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !in_tag_data && in_byte[BYTE_W-1] |=> err_cmd);
  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_cmd |=> err_cmd);
endmodule

bind ecp_rle_expander ecp_rle_expander_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_tag_data(in_tag_data),
  .in_byte(in_byte), .in_ready(in_ready), .fifo_full(fifo_full),
  .fifo_wr(fifo_wr), .fifo_data(fifo_data), .err_cmd(err_cmd)
);

// File: tb/tb_ecp_rle_expander.sv
module tb_ecp_rle_expander;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0, in_tag_data = 1'b0, fifo_full = 1'b0;
  logic [7:0] in_byte = '0;
  logic       in_ready, fifo_wr, err_cmd;
  logic [7:0] fifo_data;

  int checks = 0, fails = 0;
  int wr_cnt = 0, bad_byte = 0, wr_ready = 0, wr_full = 0;
  logic [7:0] exp_byte = '0;

  ecp_rle_expander dut (.*);

  always #10 clk = ~clk;

  always @(negedge clk) begin
    #1;
    if (rst_n && fifo_wr) begin
      wr_cnt++;
      if (fifo_data !== exp_byte) bad_byte++;
      if (in_ready) wr_ready++;
      if (fifo_full) wr_full++;
    end
  end

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input logic tag, input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1; in_tag_data = tag; in_byte = b;
    if (tag) exp_byte = b;
    #2;
    while (!in_ready) begin @(negedge clk); #2; end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drain();
    repeat (2) @(negedge clk);
    #3;
    while (!in_ready) begin @(negedge clk); #3; end
    repeat (2) @(negedge clk);
    #3;
  endtask

  task automatic clr();
    wr_cnt = 0; bad_byte = 0; wr_ready = 0; wr_full = 0;
  endtask

  task automatic t_reset();
    @(negedge clk); #2;
    check(fifo_wr == 1'b0, "R1 fifo_wr", fifo_wr, 0);
    check(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
    check(err_cmd == 1'b0, "R1 err_cmd", err_cmd, 0);
  endtask

  task automatic t_plain();
    clr();
    send(1'b1, 8'h5A); drain();
    check(wr_cnt == 1, "R2 single data", wr_cnt, 1);
    check(bad_byte == 0, "R2 data value", bad_byte, 0);
    clr();
    send(1'b0, 8'h04); drain();
    check(wr_cnt == 0, "R2 command not written", wr_cnt, 0);
    send(1'b1, 8'h00); drain();
    check(wr_cnt == 5, "R2 pending count after command", wr_cnt, 5);
  endtask

  task automatic t_count(input int n, input logic [7:0] d);
    clr();
    send(1'b0, 8'(n)); send(1'b1, d); drain();
    check(wr_cnt == n + 1, "R3 copies", wr_cnt, n + 1);
    check(bad_byte == 0, "R3 copy value", bad_byte, 0);
  endtask

  task automatic t_clear();
    clr();
    send(1'b0, 8'd6); send(1'b1, 8'hC3); drain();
    clr();
    send(1'b1, 8'h3C); drain();
    check(wr_cnt == 1, "R4 count cleared", wr_cnt, 1);
  endtask

  task automatic t_replace();
    clr();
    send(1'b0, 8'd9); send(1'b0, 8'd2); send(1'b1, 8'h77); drain();
    check(wr_cnt == 3, "R5 later count wins", wr_cnt, 3);
  endtask

  task automatic t_busy();
    clr();
    send(1'b0, 8'd4); send(1'b1, 8'h99); drain();
    check(wr_cnt == 5, "R7 copies", wr_cnt, 5);
    check(wr_ready == 0, "R7 ready low while writing", wr_ready, 0);
  endtask

  task automatic t_bad();
    clr();
    send(1'b0, 8'd3); send(1'b0, 8'h81);
    @(negedge clk); #2;
    check(err_cmd == 1'b1, "R6 error raised", err_cmd, 1);
    send(1'b1, 8'hE1); drain();
    check(wr_cnt == 4, "R6 discarded, count kept", wr_cnt, 4);
    clr();
    send(1'b0, 8'h01); send(1'b1, 8'h12); drain();
    check(err_cmd == 1'b1, "R9 error sticky", err_cmd, 1);
    check(wr_cnt == 2, "R9 traffic continues", wr_cnt, 2);
  endtask

  task automatic t_full();
    clr();
    send(1'b0, 8'd5);
    @(negedge clk); fifo_full = 1'b1;
    send(1'b1, 8'hA5);
    repeat (5) @(negedge clk);
    #2;
    check(wr_cnt == 0, "R8 stalled while full", wr_cnt, 0);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk); fifo_full = i[0];
    end
    @(negedge clk); fifo_full = 1'b0;
    drain();
    check(wr_cnt == 6, "R8 no copy lost", wr_cnt, 6);
    check(wr_full == 0, "R8 no write when full", wr_full, 0);
    check(bad_byte == 0, "R8 value kept", bad_byte, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_reset();
    t_plain();
    t_count(0, 8'h11);
    t_count(3, 8'h22);
    t_count(127, 8'hF0);
    t_clear();
    t_replace();
    t_busy();
    t_full();
    t_bad();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule